// File: doc/BRIEF.md
# Lane-Splittable 16-bit Adder

This block adds two 16-bit operands in a single combinational stage whose carry chain can be cut at bit 4, bit 8 and bit 12 under runtime control. The same hardware serves as one 16-bit adder, as two independent 8-bit adders, or as four independent 4-bit adders. The lane width can change from one cycle to the next because nothing but two select inputs has to change.

Each segment of the result holds the sum of the matching slices of the two operands, truncated to the segment width. The carry out of every segment is dropped. A small decoder turns the two mode selects into cut strobes. A datapath with a gap bit at each candidate cut position performs the addition. The gap bits are removed again at the output.

Top module: `lane_split_adder`

## Requirements
- R1: With nibbleMode=0 and byteMode=0, sumOut equals (opA + opB) mod 2^16.
- R2: With byteMode=1 and nibbleMode=0, bits [15:8] and bits [7:0] of sumOut each equal the sum of the matching operand bytes mod 2^8.
- R3: With nibbleMode=1, each of the four 4-bit fields [15:12], [11:8], [7:4] and [3:0] of sumOut equals the sum of the matching operand nibbles mod 2^4.
- R4: When both selects are 1, nibbleMode takes priority, and the result equals the R3 result.
- R5: No carry crosses an active cut. With byteMode=1, 0xFFFF+0x0001 gives 0xFF00 and 0xFFFF+0xFFFF gives 0xFEFE. With nibbleMode=1, 0xFFFF+0x0001 gives 0xFFF0.
- R6: In every mode, sumOut[3:0] equals (opA[3:0] + opB[3:0]) mod 16.
- R7: The block is combinational. A change of the mode selects alone, with the operands held, updates sumOut in the same cycle, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| nibbleMode | input | 1 | Cuts the carry at bits 4, 8 and 12 |
| byteMode | input | 1 | Cuts the carry at bit 8 |
| sumOut | output | 16 | Segment-wise sum, segment carries dropped |

## Verification
The hard case is a carry that would cross an active cut. A random operand pair produces a long carry run into a cut position only seldom. For that reason the stimulus adds directed all-ones operands, and operands plus one, in each mode. The random operands are also biased so that a fraction of them have full-ones segments. Mode switches with the operands held exercise R7, because the only thing that changes is which cuts are active.

// File: rtl/lane_split_pkg.sv
package lane_split_pkg;
  localparam int unsigned DEF_WORD_BITS = 16;
  localparam int unsigned DEF_LANE_BITS = 4;

  // Cut strobes from control to datapath: cutEven serves the points at
  // even multiples of the lane width, cutOdd the remaining points.
  typedef struct packed {
    logic cutOdd;
    logic cutEven;
  } laneCuts_t;
endpackage

// File: rtl/lane_split_ctrl.sv
module lane_split_ctrl
  import lane_split_pkg::*;
(
  input  logic      nibbleMode,
  input  logic      byteMode,
  output laneCuts_t cuts
);
  // Nibble mode cuts everywhere; byte mode cuts only at byte boundaries.
  always_comb begin
    cuts.cutEven = nibbleMode | byteMode;
    cuts.cutOdd  = nibbleMode;
  end
endmodule

// File: rtl/lane_split_datapath.sv
module lane_split_datapath
  import lane_split_pkg::*;
#(
  parameter int unsigned WORD_BITS = DEF_WORD_BITS,
  parameter int unsigned LANE_BITS = DEF_LANE_BITS
) (
  input  logic [WORD_BITS-1:0] opA,
  input  logic [WORD_BITS-1:0] opB,
  input  laneCuts_t            cuts,
  output logic [WORD_BITS-1:0] sumOut
);
  localparam int unsigned NUM_SEGS = WORD_BITS / LANE_BITS;
  localparam int unsigned NUM_PTS  = NUM_SEGS - 1;
  localparam int unsigned STRIDE   = LANE_BITS + 1;
  localparam int unsigned EXT_BITS = WORD_BITS + NUM_PTS;

  logic [EXT_BITS-1:0] extA;
  logic [EXT_BITS-1:0] extB;
  logic [EXT_BITS-1:0] extSum;
  logic [NUM_PTS-1:0]  cutVec;

  // Point k sits at bit (k+1)*LANE_BITS; odd k lands on a byte boundary.
  for (genvar k = 0; k < NUM_PTS; k++) begin : g_pts
    if ((k % 2) == 1) begin : g_even
      assign cutVec[k] = cuts.cutEven;
    end else begin : g_odd
      assign cutVec[k] = cuts.cutOdd;
    end
  end

  for (genvar s = 0; s < NUM_SEGS; s++) begin : g_segs
    assign extA[s*STRIDE +: LANE_BITS] = opA[s*LANE_BITS +: LANE_BITS];
    assign extB[s*STRIDE +: LANE_BITS] = opB[s*LANE_BITS +: LANE_BITS];
    assign sumOut[s*LANE_BITS +: LANE_BITS] = extSum[s*STRIDE +: LANE_BITS];
    if (s < NUM_PTS) begin : g_gap
      // A=1,B=0 passes the carry through; A=0,B=0 absorbs it.
      assign extA[s*STRIDE + LANE_BITS] = ~cutVec[s];
      assign extB[s*STRIDE + LANE_BITS] = 1'b0;
    end
  end

  assign extSum = extA + extB;
endmodule

// File: rtl/lane_split_adder.sv
module lane_split_adder
  import lane_split_pkg::*;
#(
  parameter int unsigned WORD_BITS = DEF_WORD_BITS,
  parameter int unsigned LANE_BITS = DEF_LANE_BITS
) (
  input  logic [WORD_BITS-1:0] opA,
  input  logic [WORD_BITS-1:0] opB,
  input  logic                 nibbleMode,
  input  logic                 byteMode,
  output logic [WORD_BITS-1:0] sumOut
);
  laneCuts_t cuts;

  lane_split_ctrl u_ctrl (
    .nibbleMode(nibbleMode),
    .byteMode  (byteMode),
    .cuts      (cuts)
  );

  lane_split_datapath #(
    .WORD_BITS(WORD_BITS),
    .LANE_BITS(LANE_BITS)
  ) u_dp (
    .opA   (opA),
    .opB   (opB),
    .cuts  (cuts),
    .sumOut(sumOut)
  );
endmodule

// File: rtl/lane_split_adder_chk.sv
module lane_split_adder_chk #(
  parameter int unsigned WORD_BITS = 16
) (
  input logic [WORD_BITS-1:0] opA,
  input logic [WORD_BITS-1:0] opB,
  input logic                 nibbleMode,
  input logic                 byteMode,
  input logic [WORD_BITS-1:0] sumOut
);
  logic [WORD_BITS-1:0] fullRef;
  logic [7:0] loByte, hiByte;
  logic [3:0] n0, n1, n2, n3;

  always_comb begin
    fullRef = opA + opB;
    loByte  = opA[7:0] + opB[7:0];
    hiByte  = opA[15:8] + opB[15:8];
    n0 = opA[3:0] + opB[3:0];
    n1 = opA[7:4] + opB[7:4];
    n2 = opA[11:8] + opB[11:8];
    n3 = opA[15:12] + opB[15:12];
  end

  always_comb begin
    if (!nibbleMode && !byteMode)
      assert_full_word_R1: assert (sumOut == fullRef);
    if (byteMode && !nibbleMode)
      assert_byte_lanes_R2: assert (sumOut == {hiByte, loByte});
    if (nibbleMode && !byteMode)
      assert_nibble_lanes_R3: assert (sumOut == {n3, n2, n1, n0});
    if (nibbleMode && byteMode)
      assert_nibble_priority_R4: assert (sumOut == {n3, n2, n1, n0});
    assert_low_nibble_R6: assert (sumOut[3:0] == n0);
  end
endmodule

bind lane_split_adder lane_split_adder_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .opA(opA), .opB(opB), .nibbleMode(nibbleMode),
  .byteMode(byteMode), .sumOut(sumOut)
);

// File: tb/lane_split_adder_test.sv
module lane_split_adder_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [15:0] opA, opB, sumOut;
  logic nibbleMode, byteMode;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  lane_split_adder uut (
    .opA(opA), .opB(opB), .nibbleMode(nibbleMode),
    .byteMode(byteMode), .sumOut(sumOut)
  );

  function automatic logic [15:0] refSum(logic [15:0] a, logic [15:0] b,
                                         logic nib, logic byt);
    int w;
    logic [15:0] r;
    logic [15:0] m;
    w = nib ? 4 : (byt ? 8 : 16);
    r = '0;
    for (int s = 0; s < 16; s += w) begin
      m = 16'((32'd1 << w) - 1) << s;
      r |= m & ((a & m) + (b & m));
    end
    return r;
  endfunction

  task automatic check(string tag, logic [15:0] exp);
    checks++;
    if (sumOut !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h nib=%b byte=%b actual=%h expected=%h",
               tag, opA, opB, nibbleMode, byteMode, sumOut, exp);
    end
  endtask

  task automatic apply(logic [15:0] a, logic [15:0] b, logic nib, logic byt);
    @(negedge clk);
    opA = a; opB = b; nibbleMode = nib; byteMode = byt;
    #1;
  endtask

  function automatic string modeTag(logic nib, logic byt);
    if (nib && byt) return "R4";
    if (nib) return "R3";
    if (byt) return "R2";
    return "R1";
  endfunction

  function automatic logic [15:0] biasedOperand();
    logic [15:0] v;
    v = 16'($urandom);
    if ($urandom_range(0, 3) == 0) v |= 16'h000F << (4 * $urandom_range(0, 3));
    return v;
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    opA = '0; opB = '0; nibbleMode = 0; byteMode = 0;
    #1;
    check("R1 idle", 16'h0000);

    // R5 directed carry-cut corners
    apply(16'hFFFF, 16'h0001, 0, 0); check("R1 wrap", 16'h0000);
    apply(16'hFFFF, 16'hFFFF, 0, 0); check("R1 ones", 16'hFFFE);
    apply(16'hFFFF, 16'h0001, 0, 1); check("R5 byte plus1", 16'hFF00);
    apply(16'hFFFF, 16'hFFFF, 0, 1); check("R5 byte ones", 16'hFEFE);
    apply(16'hFFFF, 16'h0000, 0, 1); check("R2 byte zero", 16'hFFFF);
    apply(16'hFFFF, 16'h0001, 1, 0); check("R5 nibble plus1", 16'hFFF0);
    apply(16'hFFFF, 16'hFFFF, 1, 0); check("R3 nibble ones", 16'hEEEE);
    apply(16'hFFFF, 16'hFFFF, 1, 1); check("R4 both ones", 16'hEEEE);
    apply(16'h1234, 16'h1234, 1, 0); check("R3 plain", 16'h2468);
    apply(16'hABCD, 16'hABCD, 0, 1); check("R2 plain", 16'h569A);

    // R7: operands held, only the mode changes, no clock edge in between
    apply(16'h0FFF, 16'h0001, 0, 0); check("R7 full", 16'h1000);
    byteMode = 1; #1; check("R7 to byte", 16'h0F00);
    nibbleMode = 1; #1; check("R7 to nibble", 16'h0FF0);
    nibbleMode = 0; byteMode = 0; #1; check("R7 back to full", 16'h1000);

    // Random stimulus in every mode
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 300; i++) begin
        logic [15:0] a, b;
        logic nib, byt;
        a = biasedOperand(); b = biasedOperand();
        nib = m[1]; byt = m[0];
        apply(a, b, nib, byt);
        check(modeTag(nib, byt), refSum(a, b, nib, byt));
        checks++;
        if (sumOut[3:0] !== 4'(a[3:0] + b[3:0])) begin
          errors++;
          $display("FAIL R6 actual=%h expected=%h", sumOut[3:0], 4'(a[3:0] + b[3:0]));
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule